// File: doc/BRIEF.md
# Processor Signature and Platform Flag Matcher

This block decides whether an update image is meant for the processor it runs on. It first compares the running processor's 32-bit signature and its platform flag with the image's primary signature and flag pair. If that pair does not apply and the image carries an extended signature list, the block scans the list. The list arrives as a stream of signature/flag entries, one per cycle, with a marker on the final entry.

The processor's platform flag is a one-hot byte. It is decoded from a 3-bit field in a 64-bit platform identification value. A legacy input forces the flag to zero for processors too old to report a platform. Two flag values agree when both are zero or when they share at least one set bit. The block signals its verdict with a one-cycle valid pulse and a match level that holds until the next verdict. Fetching the entries from memory and choosing between revisions are left to the surrounding logic.

Top module: `sigflag_match`

## Requirements
- R1: With `legacy_i` low, the processor flag is one-hot, with bit k set where k is the value of `plat_id_i[52:50]`.
- R2: With `legacy_i` high, the processor flag is zero whatever `plat_id_i` holds.
- R3: A signature/flag pair matches when its signature equals the processor signature and either both flags are zero or their bitwise AND is nonzero.
- R4: A `start_i` pulse accepted while idle compares the primary pair. If it matches, `res_valid_o` is high in the next cycle with `res_match_o` = 1, and no scan takes place.
- R5: If the primary pair does not match and `ext_present_i` is low, `res_valid_o` is high in the next cycle with `res_match_o` = 0.
- R6: If the primary pair does not match and `ext_present_i` is high, the block produces no verdict and enters a scan. Each entry with `ent_valid_i` high is compared against the processor signature and flag captured at start. The first matching entry gives `res_valid_o` = 1 with `res_match_o` = 1 in the following cycle, and the scan ends there.
- R7: If the entry marked by `ent_last_i` does not match, `res_valid_o` = 1 with `res_match_o` = 0 in the following cycle.
- R8: After reset `res_valid_o` and `res_match_o` are 0. `res_valid_o` is high for exactly one cycle per verdict, and `res_match_o` keeps its last verdict until the next one.
- R9: `start_i` is ignored during a scan, and entries presented while idle or after a scan has ended are ignored. In both cases no verdict results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a check using the processor and primary inputs |
| cpu_sig_i | input | 32 | Signature of the running processor |
| plat_id_i | input | 64 | Platform identification value; bits 52:50 select the flag bit |
| legacy_i | input | 1 | Processor predates platform flags; forces its flag to zero |
| prim_sig_i | input | 32 | Primary signature of the image |
| prim_flags_i | input | 8 | Primary platform flags of the image |
| ext_present_i | input | 1 | Image carries a non-empty extended signature list |
| ent_valid_i | input | 1 | Extended entry present this cycle |
| ent_sig_i | input | 32 | Extended entry signature |
| ent_flags_i | input | 8 | Extended entry platform flags |
| ent_last_i | input | 1 | Marks the final extended entry |
| res_valid_o | output | 1 | One-cycle verdict pulse |
| res_match_o | output | 1 | Verdict: image applies; held between verdicts |

## Verification
The assertions assume that the caller drives the primary fields and `ext_present_i` together with `start_i`. They also assume that a non-empty list always ends with an entry carrying `ent_last_i`. Without that, a scan could stay open forever, and the one-verdict-per-scan properties would never be exercised. The stimulus keeps within these assumptions: every scan it opens is closed, either by a matching entry or by a marked last entry. Stray starts and stray entries are sent only in deliberate tests that expect them to be ignored.

// File: rtl/sigflag_pkg.sv
package sigflag_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/sigflag_decode.sv
module sigflag_decode #(
  parameter int REG_W  = 64,
  parameter int IDX_LSB = 50,
  parameter int IDX_W  = 3,
  localparam int FLAG_W = 1 << IDX_W
) (
  input  logic [REG_W-1:0]  plat_id_i,
  input  logic              legacy_i,
  output logic [FLAG_W-1:0] flag_o
);
  logic [IDX_W-1:0] idx;

  assign idx = plat_id_i[IDX_LSB +: IDX_W];

  for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
    assign flag_o[g] = !legacy_i && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/sigflag_cmp.sv
module sigflag_cmp #(
  parameter int SIG_W  = 32,
  parameter int FLAG_W = 8
) (
  input  logic [SIG_W-1:0]  a_sig_i,
  input  logic [FLAG_W-1:0] a_flag_i,
  input  logic [SIG_W-1:0]  b_sig_i,
  input  logic [FLAG_W-1:0] b_flag_i,
  output logic              hit_o
);
  logic sig_eq;
  logic both_zero;
  logic overlap;

  always_comb begin
    sig_eq    = (a_sig_i == b_sig_i);
    both_zero = (a_flag_i == '0) && (b_flag_i == '0);
    overlap   = |(a_flag_i & b_flag_i);
    hit_o     = sig_eq && (both_zero || overlap);
  end
endmodule

// File: rtl/sigflag_scan_fsm.sv
module sigflag_scan_fsm
  import sigflag_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ext_present_i,
  input  logic prim_hit_i,
  input  logic ent_valid_i,
  input  logic ent_last_i,
  input  logic ent_hit_i,
  output logic load_o,
  output logic scanning_o,
  output logic res_valid_o,
  output logic res_match_o
);
  scan_st_e st_q, st_d;
  logic     valid_q, valid_d;
  logic     match_q, match_d;
  logic     match_en;

  always_comb begin
    st_d     = st_q;
    valid_d  = 1'b0;
    match_d  = match_q;
    match_en = 1'b0;
    load_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          if (prim_hit_i) begin
            valid_d  = 1'b1;
            match_d  = 1'b1;
            match_en = 1'b1;
          end else if (!ext_present_i) begin
            valid_d  = 1'b1;
            match_d  = 1'b0;
            match_en = 1'b1;
          end else begin
            st_d = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (ent_valid_i) begin
          if (ent_hit_i) begin
            valid_d  = 1'b1;
            match_d  = 1'b1;
            match_en = 1'b1;
            st_d     = ST_IDLE;
          end else if (ent_last_i) begin
            valid_d  = 1'b1;
            match_d  = 1'b0;
            match_en = 1'b1;
            st_d     = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      valid_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      if (match_en) begin
        match_q <= match_d;
      end
    end
  end

  assign scanning_o  = (st_q == ST_SCAN);
  assign res_valid_o = valid_q;
  assign res_match_o = match_q;
endmodule

// File: rtl/sigflag_match.sv
module sigflag_match #(
  parameter int SIG_W   = 32,
  parameter int REG_W   = 64,
  parameter int IDX_LSB = 50,
  parameter int IDX_W   = 3,
  localparam int FLAG_W = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIG_W-1:0]  cpu_sig_i,
  input  logic [REG_W-1:0]  plat_id_i,
  input  logic              legacy_i,
  input  logic [SIG_W-1:0]  prim_sig_i,
  input  logic [FLAG_W-1:0] prim_flags_i,
  input  logic              ext_present_i,
  input  logic              ent_valid_i,
  input  logic [SIG_W-1:0]  ent_sig_i,
  input  logic [FLAG_W-1:0] ent_flags_i,
  input  logic              ent_last_i,
  output logic              res_valid_o,
  output logic              res_match_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [FLAG_W-1:0] cur_flag;
  logic [SIG_W-1:0]  sig_q, sig_d;
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic              load;
  logic              scanning;
  logic              prim_hit;
  logic              ent_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  sigflag_decode #(
    .REG_W(REG_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)
  ) u_decode (
    .plat_id_i(plat_id_i),
    .legacy_i (legacy_i),
    .flag_o   (cur_flag)
  );

  sigflag_cmp #(.SIG_W(SIG_W), .FLAG_W(FLAG_W)) u_prim_cmp (
    .a_sig_i (cpu_sig_i),
    .a_flag_i(cur_flag),
    .b_sig_i (prim_sig_i),
    .b_flag_i(prim_flags_i),
    .hit_o   (prim_hit)
  );

  always_comb begin
    sig_d  = load ? cpu_sig_i : sig_q;
    flag_d = load ? cur_flag  : flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sig_q  <= '0;
      flag_q <= '0;
    end else begin
      sig_q  <= sig_d;
      flag_q <= flag_d;
    end
  end

  sigflag_cmp #(.SIG_W(SIG_W), .FLAG_W(FLAG_W)) u_ent_cmp (
    .a_sig_i (sig_q),
    .a_flag_i(flag_q),
    .b_sig_i (ent_sig_i),
    .b_flag_i(ent_flags_i),
    .hit_o   (ent_hit)
  );

  sigflag_scan_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .start_i      (start_i),
    .ext_present_i(ext_present_i),
    .prim_hit_i   (prim_hit),
    .ent_valid_i  (ent_valid_i),
    .ent_last_i   (ent_last_i),
    .ent_hit_i    (ent_hit),
    .load_o       (load),
    .scanning_o   (scanning),
    .res_valid_o  (res_valid_o),
    .res_match_o  (res_match_o)
  );
endmodule

// File: rtl/sigflag_match_chk.sv
module sigflag_match_chk #(
  parameter int REG_W   = 64,
  parameter int IDX_LSB = 50,
  parameter int IDX_W   = 3,
  parameter int FLAG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ext_present,
  input logic              legacy,
  input logic [REG_W-1:0]  plat_id,
  input logic              ent_valid,
  input logic              ent_last,
  input logic              prim_hit,
  input logic              ent_hit,
  input logic              scanning,
  input logic [FLAG_W-1:0] cur_flag,
  input logic              res_valid,
  input logic              res_match
);
  p_flag_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy |-> ($countones(cur_flag) == 1 && cur_flag[plat_id[IDX_LSB +: IDX_W]]));

  p_flag_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    legacy |-> cur_flag == '0);

  p_prim_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !scanning && prim_hit) |=> (res_valid && res_match && !scanning));

  p_prim_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !scanning && !prim_hit && !ext_present) |=> (res_valid && !res_match));

  p_enter_scan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !scanning && !prim_hit && ext_present) |=> (scanning && !res_valid));

  p_first_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && ent_valid && ent_hit) |=> (res_valid && res_match && !scanning));

  p_last_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && ent_valid && ent_last && !ent_hit) |=> (res_valid && !res_match));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_match));

  p_no_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !ent_valid) |=> !res_valid);

  p_idle_ent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scanning && !start) |=> !res_valid);
endmodule

bind sigflag_match sigflag_match_chk #(
  .REG_W(REG_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .FLAG_W(FLAG_W)
) u_chk (
  .clk        (clk_i),
  .rst_n      (rst_sync_n),
  .start      (start_i),
  .ext_present(ext_present_i),
  .legacy     (legacy_i),
  .plat_id    (plat_id_i),
  .ent_valid  (ent_valid_i),
  .ent_last   (ent_last_i),
  .prim_hit   (prim_hit),
  .ent_hit    (ent_hit),
  .scanning   (scanning),
  .cur_flag   (cur_flag),
  .res_valid  (res_valid_o),
  .res_match  (res_match_o)
);

// File: tb/sim_sigflag_match.sv
module sim_sigflag_match;
  localparam int NV = 8;
  localparam logic [31:0] SA = 32'h000906A4;
  localparam logic [31:0] SB = 32'h000806C1;

  localparam logic [31:0] V_CPU [NV] = '{SA, SA, SA, SA, SA, SB, SA, SA};
  localparam logic [2:0]  V_IDX [NV] = '{3'd3, 3'd3, 3'd0, 3'd4, 3'd7, 3'd7, 3'd7, 3'd5};
  localparam logic        V_LEG [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0] V_PSG [NV] = '{SA, SA, SA, SA, SA, SA, SA, SA};
  localparam logic [7:0]  V_PFL [NV] = '{8'h08, 8'h14, 8'h00, 8'h01, 8'h00, 8'hFF, 8'hFF, 8'h21};
  localparam logic        V_EXP [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] cpu_sig;
  logic [63:0] plat_id;
  logic        legacy;
  logic [31:0] prim_sig;
  logic [7:0]  prim_flags;
  logic        ext_present;
  logic        ent_valid;
  logic [31:0] ent_sig;
  logic [7:0]  ent_flags;
  logic        ent_last;
  logic        res_valid;
  logic        res_match;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sigflag_match u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cpu_sig_i(cpu_sig),
    .plat_id_i(plat_id), .legacy_i(legacy), .prim_sig_i(prim_sig),
    .prim_flags_i(prim_flags), .ext_present_i(ext_present),
    .ent_valid_i(ent_valid), .ent_sig_i(ent_sig), .ent_flags_i(ent_flags),
    .ent_last_i(ent_last), .res_valid_o(res_valid), .res_match_o(res_match)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual={valid,match}=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [31:0] sig, input logic [2:0] idx, input logic leg,
                          input logic [31:0] psig, input logic [7:0] pfl, input logic ext);
    @(negedge clk);
    start = 1'b1; cpu_sig = sig; plat_id = 64'(idx) << 50; legacy = leg;
    plat_id[7:0] = 8'hA5;
    prim_sig = psig; prim_flags = pfl; ext_present = ext;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_ent(input logic [31:0] sig, input logic [7:0] fl, input logic last);
    @(negedge clk);
    ent_valid = 1'b1; ent_sig = sig; ent_flags = fl; ent_last = last;
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cpu_sig = '0; plat_id = '0; legacy = 1'b0;
    prim_sig = '0; prim_flags = '0; ext_present = 1'b0;
    ent_valid = 1'b0; ent_sig = '0; ent_flags = '0; ent_last = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset state", {res_valid, res_match}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 after reset release", {res_valid, res_match}, 2'b00);

    // Table: primary pair only (R1 R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      do_start(V_CPU[i], V_IDX[i], V_LEG[i], V_PSG[i], V_PFL[i], 1'b0);
      chk($sformatf("R3 R4 R5 vector %0d", i), {res_valid, res_match}, {1'b1, V_EXP[i]});
      @(negedge clk);
      chk($sformatf("R8 pulse ends, vector %0d", i), {res_valid, res_match}, {1'b0, V_EXP[i]});
    end

    // R1: each flag bit position selected by plat_id[52:50]
    for (int k = 0; k < 8; k++) begin
      do_start(SA, 3'(k), 1'b0, SA, 8'(1 << k), 1'b0);
      chk($sformatf("R1 flag bit %0d matches", k), {res_valid, res_match}, 2'b11);
      do_start(SA, 3'(k), 1'b0, SA, ~8'(1 << k), 1'b0);
      chk($sformatf("R1 flag bit %0d disjoint", k), {res_valid, res_match}, 2'b10);
    end

    // R4: primary match with ext list present; no scan opened
    do_start(SA, 3'd1, 1'b0, SA, 8'h02, 1'b1);
    chk("R4 primary hit skips scan", {res_valid, res_match}, 2'b11);
    do_ent(SB, 8'h02, 1'b1);
    chk("R9 entry after primary hit ignored", {res_valid, res_match}, 2'b01);

    // R6: scan with first match in the middle
    do_start(SA, 3'd2, 1'b0, SB, 8'h04, 1'b1);
    chk("R6 scan entered, no verdict", {res_valid, res_match}, 2'b01);
    do_ent(SB, 8'h04, 1'b0);
    chk("R6 sig mismatch entry", res_valid, 1'b0);
    do_ent(SA, 8'h08, 1'b0);
    chk("R3 disjoint flags entry", res_valid, 1'b0);
    do_ent(SA, 8'h0C, 1'b0);
    chk("R6 first matching entry", {res_valid, res_match}, 2'b11);
    do_ent(SA, 8'h01, 1'b1);
    chk("R9 entry after scan end ignored", {res_valid, res_match}, 2'b01);
    repeat (3) @(negedge clk);
    chk("R8 match held", {res_valid, res_match}, 2'b01);

    // R7: scan ends on last entry with no match
    do_start(SA, 3'd2, 1'b0, SA, 8'h01, 1'b1);
    chk("R6 scan entered after primary flag miss", res_valid, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk("R6 idle gap in stream", res_valid, 1'b0);
    do_ent(SB, 8'h04, 1'b0);
    do_ent(SA, 8'h01, 1'b1);
    chk("R7 last entry no match", {res_valid, res_match}, 2'b10);

    // R9: entry while idle ignored
    do_ent(SA, 8'hFF, 1'b1);
    chk("R9 idle entry ignored", {res_valid, res_match}, 2'b00);

    // R9: start during scan ignored
    do_start(SA, 3'd6, 1'b0, SB, 8'h40, 1'b1);
    do_start(SA, 3'd6, 1'b0, SA, 8'h40, 1'b0);
    chk("R9 start during scan ignored", {res_valid, res_match}, 2'b00);
    do_ent(SA, 8'h40, 1'b1);
    chk("R6 scan still open after stray start", {res_valid, res_match}, 2'b11);

    // R2 R3: legacy processor, zero-flag entry matches in scan
    do_start(SA, 3'd5, 1'b1, SA, 8'h20, 1'b1);
    chk("R2 legacy flag zero, primary miss", res_valid, 1'b0);
    do_ent(SA, 8'h20, 1'b0);
    chk("R2 legacy vs nonzero entry", res_valid, 1'b0);
    do_ent(SA, 8'h00, 1'b1);
    chk("R3 both zero flags match", {res_valid, res_match}, 2'b11);

    // R6: captured processor fields used, not live inputs
    do_start(SA, 3'd0, 1'b0, SB, 8'h01, 1'b1);
    cpu_sig = SB; plat_id = 64'(3'd7) << 50;
    do_ent(SA, 8'h01, 1'b1);
    chk("R6 entry uses captured signature and flag", {res_valid, res_match}, 2'b11);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule